// File: doc/BRIEF.md
# Dual-Clock Programmable-Threshold FIFO

This block is a first-in first-out buffer for 9-bit words with a parametric depth of 256 words by default. The write port and the read port each have their own clock. The two clocks may be tied together or may run with no fixed phase relation. A port acts only when both of its active-high enables are high. The write side accepts a word on a rising write-clock edge. The read side moves the oldest word into a registered output on a rising read-clock edge.

The block drives four status flags. Empty and almost-empty are computed in the read clock domain. Full and almost-full are computed in the write clock domain. The two almost thresholds come from a pair of offset registers. Both offsets reset to 7. While the `load` input is high, an enabled write cycle stores the low bits of `din` into an offset register instead of the RAM. An enabled read cycle copies an offset register onto the output instead of popping a word. Both paths visit the almost-empty offset first and the almost-full offset second, then return to the first. An output enable either passes the output register to `dout` or forces `dout` to zero and drops `dout_drv`.

Top module: `sfifo_prog`

## Requirements
- R1: A word from `din` is stored on a rising `wclk` edge only when `wen_a` and `wen_b` are both 1, `load` is 0 and `full` is 0. A cycle with only one write enable stores nothing.
- R2: The oldest word is moved into the output register on a rising `rclk` edge only when `ren_a` and `ren_b` are both 1, `load` is 0 and `empty` is 0. Otherwise the output register holds its value.
- R3: `full` is 1 when the block holds DEPTH words. A write attempted while full is discarded, and no stored word is altered.
- R4: A read attempted while `empty` is 1 leaves the output register and the read position unchanged.
- R5: A synchronous active-high `rst` sets `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and the output register to 0. It also restores both offsets to 7, so after reset 8 stored words clear `almost_empty` and DEPTH-7 words set `almost_full`.
- R6: `almost_empty` is 1 exactly when the word count seen in the read domain is at or below the almost-empty offset.
- R7: `almost_full` is 1 exactly when the word count seen in the write domain is at or above DEPTH minus the almost-full offset.
- R8: With `load`=1, each enabled write cycle stores `din` into an offset register instead of the RAM. The first cycle stores the almost-empty offset and the second stores the almost-full offset, then the order repeats. No word is added to the buffer.
- R9: With `load`=1, each enabled read cycle copies an offset register, zero-extended, into the output register. The order is almost-empty offset, then almost-full offset, then the order repeats. No word is removed from the buffer.
- R10: When `oe` is 0, `dout` is all zeros and `dout_drv` is 0. When `oe` is 1, `dout` shows the output register and `dout_drv` is 1.
- R11: A write pointer change reaches the read domain through two `rclk` flops. `empty` therefore clears on the second `rclk` edge after the write edge, with the clocks tied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| wen_a | input | 1 | First write enable |
| wen_b | input | 1 | Second write enable |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| load | input | 1 | Redirects enabled accesses to the offset registers |
| oe | input | 1 | Output enable for `dout` |
| din | input | 9 | Write data, or offset value while loading |
| dout | output | 9 | Output register when `oe` is 1, else zero |
| dout_drv | output | 1 | High while `dout` is driven |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | DEPTH words visible to the write side |
| almost_empty | output | 1 | Read-side count at or below the almost-empty offset |
| almost_full | output | 1 | Write-side count at or above DEPTH minus the almost-full offset |

## Verification
With the clocks tied, a popped word or a read-back offset is in `dout` one edge after the enabling edge. The bench samples `dout` on the falling edge that follows. `full` reacts to writes, and `empty` reacts to reads, in that same cycle, because each is computed in its own domain. Flags that depend on the other domain's pointer lag by two edges. The bench therefore waits three idle cycles before it checks any flag. It also checks the exact two-edge delay of `empty` after a single write cycle by cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int DEF_OFFSET = 7;
    localparam int GMAX       = 16;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } off_sel_e;

    typedef struct packed {
        logic load;
        logic both;
    } port_req_t;

    function automatic off_sel_e sel_next(input off_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    function automatic logic [GMAX-1:0] bin2gray(input logic [GMAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GMAX-1:0] gray2bin(input logic [GMAX-1:0] g);
        logic [GMAX-1:0] b;
        b[GMAX-1] = g[GMAX-1];
        for (int i = GMAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sfp_ram.sv
module sfp_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfp_wside.sv
module sfp_wside
    import sfp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  port_req_t     req,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          ram_we,
    output logic          full,
    output logic          almost_full,
    output logic [AW-1:0] off_ae,
    output logic [AW-1:0] off_af
);
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wbin_nx;
    off_sel_e      sel;

    assign rbin_s      = PW'(gray2bin(GMAX'(rgray_s)));
    assign wcount      = wbin - rbin_s;
    assign full        = (wcount == PW'(DEPTH));
    assign almost_full = (wcount >= (PW'(DEPTH) - PW'(off_af)));
    assign ram_we      = req.both && !req.load && !full;
    assign wbin_nx     = wbin + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            sel    <= SEL_AE;
            off_ae <= AW'(DEF_OFFSET);
            off_af <= AW'(DEF_OFFSET);
        end else begin
            if (ram_we) begin
                wbin  <= wbin_nx;
                wgray <= PW'(bin2gray(GMAX'(wbin_nx)));
            end
            if (req.both && req.load) begin
                if (sel == SEL_AE) begin
                    off_ae <= AW'(din);
                end else begin
                    off_af <= AW'(din);
                end
                sel <= sel_next(sel);
            end
        end
    end
endmodule

// File: rtl/sfp_rside.sv
module sfp_rside
    import sfp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  port_req_t     req,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] ram_rdata,
    input  logic [AW-1:0] off_ae,
    input  logic [AW-1:0] off_af,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          almost_empty,
    output logic [DW-1:0] q
);
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rbin_nx;
    off_sel_e      sel;

    assign wbin_s       = PW'(gray2bin(GMAX'(wgray_s)));
    assign rcount       = wbin_s - rbin;
    assign empty        = (rcount == '0);
    assign almost_empty = (rcount <= PW'(off_ae));
    assign rbin_nx      = rbin + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            q     <= '0;
            sel   <= SEL_AE;
        end else if (req.both) begin
            if (req.load) begin
                q   <= (sel == SEL_AE) ? DW'(off_ae) : DW'(off_af);
                sel <= sel_next(sel);
            end else if (!empty) begin
                q     <= ram_rdata;
                rbin  <= rbin_nx;
                rgray <= PW'(bin2gray(GMAX'(rbin_nx)));
            end
        end
    end
endmodule

// File: rtl/sfifo_prog.sv
module sfifo_prog
    import sfp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 9
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wen_a,
    input  logic          wen_b,
    input  logic          ren_a,
    input  logic          ren_b,
    input  logic          load,
    input  logic          oe,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_drv,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    port_req_t     wreq, rreq;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_s, rgray_s;
    logic          ram_we;
    logic [AW-1:0] off_ae, off_af;
    logic [DW-1:0] ram_rdata, q;

    assign wreq = '{load: load, both: wen_a & wen_b};
    assign rreq = '{load: load, both: ren_a & ren_b};

    sfp_wside #(.DEPTH(DEPTH), .DW(DW)) u_wside (
        .clk(wclk), .rst(rst), .req(wreq), .din(din), .rgray_s(rgray_s),
        .wbin(wbin), .wgray(wgray), .ram_we(ram_we), .full(full),
        .almost_full(almost_full), .off_ae(off_ae), .off_af(off_af)
    );

    sfp_rside #(.DEPTH(DEPTH), .DW(DW)) u_rside (
        .clk(rclk), .rst(rst), .req(rreq), .wgray_s(wgray_s),
        .ram_rdata(ram_rdata), .off_ae(off_ae), .off_af(off_af),
        .rbin(rbin), .rgray(rgray), .empty(empty),
        .almost_empty(almost_empty), .q(q)
    );

    sfp_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    sfp_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    sfp_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .wclk(wclk), .we(ram_we), .waddr(wbin[AW-1:0]), .wdata(din),
        .raddr(rbin[AW-1:0]), .rdata(ram_rdata)
    );

    assign dout     = oe ? q : '0;
    assign dout_drv = oe;
endmodule

// File: rtl/sfifo_prog_chk.sv
module sfifo_prog_chk #(
    parameter int PW = 9,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wen_a,
    input logic          wen_b,
    input logic          ren_a,
    input logic          ren_b,
    input logic          load,
    input logic          oe,
    input logic [DW-1:0] dout,
    input logic          dout_drv,
    input logic          empty,
    input logic          full,
    input logic          almost_empty,
    input logic          almost_full,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    assert_reset_rflags_R5: assert property (@(posedge rclk)
        rst |=> (empty && almost_empty));
    assert_reset_wflags_R5: assert property (@(posedge wclk)
        rst |=> (!full && !almost_full));
    assert_write_needs_both_R1: assert property (@(posedge wclk) disable iff (rst)
        !(wen_a && wen_b) |=> $stable(wbin));
    assert_read_needs_both_R2: assert property (@(posedge rclk) disable iff (rst)
        !(ren_a && ren_b) |=> $stable(rbin));
    assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (rst)
        (full && wen_a && wen_b) |=> $stable(wbin));
    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
        (empty && ren_a && ren_b) |=> $stable(rbin));
    assert_empty_in_ae_R6: assert property (@(posedge rclk) disable iff (rst)
        empty |-> almost_empty);
    assert_full_in_af_R7: assert property (@(posedge wclk) disable iff (rst)
        full |-> almost_full);
    assert_load_keeps_wptr_R8: assert property (@(posedge wclk) disable iff (rst)
        load |=> $stable(wbin));
    assert_load_keeps_rptr_R9: assert property (@(posedge rclk) disable iff (rst)
        load |=> $stable(rbin));
    assert_oe_off_R10: assert property (@(posedge rclk) disable iff (rst)
        !oe |-> (dout == '0 && !dout_drv));
endmodule

bind sfifo_prog sfifo_prog_chk #(.PW(PW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wen_a(wen_a), .wen_b(wen_b),
    .ren_a(ren_a), .ren_b(ren_b), .load(load), .oe(oe), .dout(dout),
    .dout_drv(dout_drv), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .wbin(wbin), .rbin(rbin)
);

// File: tb/sim_sfifo_prog.sv
module sim_sfifo_prog;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int WD_CYCLES  = 20000;

    typedef struct packed {
        logic [9:0] nwr;
        logic [9:0] nrd;
        logic       e;
        logic       ae;
        logic       af;
        logic       f;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{10'd1,   10'd0,   1'b0, 1'b1, 1'b0, 1'b0},
        '{10'd6,   10'd0,   1'b0, 1'b1, 1'b0, 1'b0},
        '{10'd1,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0},
        '{10'd241, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0},
        '{10'd0,   10'd1,   1'b0, 1'b0, 1'b0, 1'b0},
        '{10'd10,  10'd0,   1'b0, 1'b0, 1'b1, 1'b1},
        '{10'd0,   10'd258, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wen_a = 1'b0, wen_b = 1'b0, ren_a = 1'b0, ren_b = 1'b0;
    logic       load = 1'b0, oe = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_drv, empty, full, almost_empty, almost_full;

    int         checks = 0;
    int         fails  = 0;
    int         seq    = 0;
    logic [8:0] last   = '0;
    logic [8:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sfifo_prog #(.DEPTH(DEPTH), .DW(9)) u0 (
        .wclk(clk), .rclk(clk), .rst(rst), .wen_a(wen_a), .wen_b(wen_b),
        .ren_a(ren_a), .ren_b(ren_b), .load(load), .oe(oe), .din(din),
        .dout(dout), .dout_drv(dout_drv), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic flags(input string tag, input logic e, input logic ae,
                         input logic af, input logic f);
        chk({tag, " R4 empty"}, 32'(empty), 32'(e));
        chk({tag, " R6 almost_empty"}, 32'(almost_empty), 32'(ae));
        chk({tag, " R7 almost_full"}, 32'(almost_full), 32'(af));
        chk({tag, " R3 full"}, 32'(full), 32'(f));
    endtask

    task automatic do_write(input int n);
        for (int i = 0; i < n; i++) begin
            din   = 9'((seq * 37 + 5) & 9'h1ff);
            wen_a = 1'b1;
            wen_b = 1'b1;
            if (model.size() < DEPTH) model.push_back(din);
            seq++;
            @(negedge clk);
        end
        wen_a = 1'b0;
        wen_b = 1'b0;
    endtask

    task automatic do_read(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            ren_a = 1'b1;
            ren_b = 1'b1;
            @(negedge clk);
            if (model.size() > 0) last = model.pop_front();
            chk(tag, 32'(dout), 32'(last));
        end
        ren_a = 1'b0;
        ren_b = 1'b0;
    endtask

    task automatic load_wr(input logic [8:0] v);
        load = 1'b1; wen_a = 1'b1; wen_b = 1'b1; din = v;
        @(negedge clk);
        load = 1'b0; wen_a = 1'b0; wen_b = 1'b0;
    endtask

    task automatic load_rd(input logic [8:0] exp);
        load = 1'b1; ren_a = 1'b1; ren_b = 1'b1;
        @(negedge clk);
        load = 1'b0; ren_a = 1'b0; ren_b = 1'b0;
        last = exp;
        chk("R9 offset readback", 32'(dout), 32'(exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model.delete();
        last = '0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R5 reset state
        flags("R5 reset", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 dout reset", 32'(dout), 32'h0);

        // table walk: R1 R2 R3 R4 R6 R7
        for (int r = 0; r < 7; r++) begin
            do_write(int'(TBL[r].nwr));
            do_read(int'(TBL[r].nrd), "R2 R4 read data");
            settle();
            flags("table", TBL[r].e, TBL[r].ae, TBL[r].af, TBL[r].f);
        end

        // R11: empty clears two read edges after the write edge
        din = 9'h0a5; wen_a = 1'b1; wen_b = 1'b1;
        model.push_back(din);
        @(negedge clk);
        wen_a = 1'b0; wen_b = 1'b0;
        chk("R11 empty +0", 32'(empty), 32'h1);
        @(negedge clk);
        chk("R11 empty +1", 32'(empty), 32'h1);
        @(negedge clk);
        chk("R11 empty +2", 32'(empty), 32'h0);

        // R2: one read enable only, output holds
        ren_a = 1'b1; @(negedge clk); ren_a = 1'b0;
        chk("R2 ren_a only", 32'(dout), 32'(last));
        ren_b = 1'b1; @(negedge clk); ren_b = 1'b0;
        chk("R2 ren_b only", 32'(dout), 32'(last));
        do_read(1, "R2 read after single enables");

        // R1: one write enable only, nothing stored
        settle();
        din = 9'h1ff; wen_a = 1'b1; @(negedge clk); wen_a = 1'b0;
        wen_b = 1'b1; @(negedge clk); wen_b = 1'b0;
        settle();
        chk("R1 single enable no store", 32'(empty), 32'h1);

        // R8: load offsets, buffer untouched
        load_wr(9'd20);
        load_wr(9'd30);
        settle();
        chk("R8 load adds no word", 32'(empty), 32'h1);
        do_write(20);
        settle();
        chk("R8 R6 ae at offset 20", 32'(almost_empty), 32'h1);
        do_write(1);
        settle();
        chk("R8 R6 ae above offset 20", 32'(almost_empty), 32'h0);
        do_write(204);
        settle();
        chk("R8 R7 af below 226", 32'(almost_full), 32'h0);
        do_write(1);
        settle();
        chk("R8 R7 af at 226", 32'(almost_full), 32'h1);

        // R9: readback order and wrap, then data still intact
        load_rd(9'd20);
        load_rd(9'd30);
        load_rd(9'd20);
        settle();
        chk("R9 readback keeps words", 32'(almost_full), 32'h1);

        // R10: output enable
        oe = 1'b0; @(negedge clk);
        chk("R10 dout forced zero", 32'(dout), 32'h0);
        chk("R10 drv low", 32'(dout_drv), 32'h0);
        oe = 1'b1; @(negedge clk);
        chk("R10 dout restored", 32'(dout), 32'(last));
        chk("R10 drv high", 32'(dout_drv), 32'h1);

        do_read(226, "R9 data after readback");
        settle();
        chk("R4 drained", 32'(empty), 32'h1);

        // R5: reset restores default offsets of 7
        do_write(5);
        do_reset();
        settle();
        flags("R5 second reset", 1'b1, 1'b1, 1'b0, 1'b0);
        do_write(8);
        settle();
        chk("R5 default ae offset", 32'(almost_empty), 32'h0);
        do_write(240);
        settle();
        chk("R5 default af below", 32'(almost_full), 32'h0);
        do_write(1);
        settle();
        chk("R5 default af at 249", 32'(almost_full), 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule